// File: doc/BRIEF.md
# DMA Channel Register Set and Request Control

This block keeps the programming state of an eight-channel DMA engine and decides the outcome of each transfer request that a device raises. Every channel owns four 32-bit words in a memory-mapped register window: a spare word, a control/status word, a remaining byte count and a start address. Software programs these words with single-cycle writes and reads them back combinationally.

A device asks for a transfer by raising its channel's request line. It gives a direction (into memory or out of memory) and a byte length with the request. The block serves one request per cycle, always the lowest-numbered channel that is asking. It checks the request against the channel's enable and direction bits. It then returns, one cycle later, a pass/fail result together with the start address and the granted length. It updates the channel's status bits and remaining count. A failed request also leaves a sticky per-channel bit in a shared error-source register. Moving the data and translating the address are done elsewhere.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every channel word reads 0, the error-source register reads 0, `rsp_vld` is 0 and `req_ack` is 0.
- R2: Register map, 32-bit accesses. Channel n word k (k = 0..3) is at byte offset 0x100 + 0x20·n + 8·k. The error-source register is at 0x200. Address bits [1:0] are ignored. Any other offset, including those with bit 2 set inside the channel window, reads 0 and ignores writes.
- R3: Control word bits: 0 = enable, 1 = memory-to-device direction, 8 = transfer done, 9 = request error, 10 = address error. Serving a request first clears bits 8, 9 and 10 of that channel. It then sets exactly one of bits 8 or 9.
- R4: A request fails when bit 0 is clear, or when its direction disagrees with bit 1. `req_to_mem`=1 needs bit 1 clear, and `req_to_mem`=0 needs bit 1 set. On failure bit 9 is set, the count is unchanged, and bit n of the error-source register becomes 1. The response carries `rsp_ok`=0, `rsp_addr`=0 and `rsp_len`=0.
- R5: A request that passes is granted min(requested length, count) bytes. It sets bit 8 and subtracts the granted length from the count. The response carries `rsp_ok`=1, the channel's address word and the granted length.
- R6: When several channels request at once, the lowest-numbered one is served, one channel per cycle. `req_ack` is one-hot on the served channel in the cycle it is served. The response (`rsp_vld`, `rsp_ch`) follows at the next clock edge.
- R7: If software writes a channel word in the same cycle that a served request updates that word, the software value is kept.
- R8: The error-source register is read-only. Software writes to 0x200 have no effect, and its bits stay set until reset.
- R9: Word 0 of each channel is plain read/write storage that requests never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register window byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| req_vld | input | NUM_CH | Per-channel transfer request |
| req_to_mem | input | NUM_CH | Per-channel direction: 1 = device to memory |
| req_len | input | NUM_CH*32 | Per-channel requested length, channel n in bits [32n+31:32n] |
| req_ack | output | NUM_CH | One-hot: channel served this cycle |
| rsp_vld | output | 1 | Response valid |
| rsp_ch | output | CH_W | Channel of the response |
| rsp_ok | output | 1 | Request passed the checks |
| rsp_addr | output | 32 | Start address (0 on failure) |
| rsp_len | output | 32 | Granted length (0 on failure) |

## Verification
A software write to a channel's control or count word can land in the same cycle as that channel's request being served, since both touch the same registers. The bench provokes this on purpose: it raises a request and, in that same cycle, drives a write to the served channel's count word, and in another case to its control word. A random phase later repeats the collision at random. A behavioural model applies the request first and the software write over it. Read-back of the word after the cycle shows whether the software value survived.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int WORD_W       = 32;
    localparam int WORDS_PER_CH = 4;

    localparam logic [31:0] CH_BASE   = 32'h100;
    localparam logic [31:0] CH_STRIDE = 32'h20;
    localparam logic [31:0] ERR_OFS   = 32'h200;

    localparam int W_SPARE = 0;
    localparam int W_FLAGS = 1;
    localparam int W_COUNT = 2;
    localparam int W_ADDR  = 3;

    localparam int F_EN   = 0;
    localparam int F_M2D  = 1;
    localparam int F_TC   = 8;
    localparam int F_MERR = 9;
    localparam int F_AERR = 10;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic       hit_ch;
        logic       hit_err;
        logic [7:0] ch;
        logic [1:0] idx;
    } dec_t;

    typedef struct packed {
        logic  upd;
        logic  ok;
        word_t len;
    } hw_op_t;

    function automatic dec_t decode(input logic [31:0] byte_addr, input int num_ch);
        logic [31:0] a;
        logic [31:0] off;
        dec_t d;
        a   = byte_addr & ~32'h3;
        off = a - CH_BASE;
        d   = '0;
        d.hit_err = (a == ERR_OFS);
        if (a >= CH_BASE && off < (32'(num_ch) * CH_STRIDE) && a[2] == 1'b0) begin
            d.hit_ch = 1'b1;
            d.ch     = off[12:5];
            d.idx    = off[4:3];
        end
        return d;
    endfunction

    function automatic word_t clamp_len(input word_t want, input word_t left);
        return (want < left) ? want : left;
    endfunction

    function automatic logic req_legal(input word_t flags, input logic to_mem);
        return flags[F_EN] && (to_mem == ~flags[F_M2D]);
    endfunction

endpackage

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   req,
    output logic [NUM-1:0]   gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_ctl_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [WORDS_PER_CH-1:0]                sw_we,
    input  word_t                                  sw_data,
    input  hw_op_t                                 op,
    output logic [WORDS_PER_CH-1:0][WORD_W-1:0]    words
);
    localparam word_t STAT_MASK = word_t'((1 << F_TC) | (1 << F_MERR) | (1 << F_AERR));

    word_t flags_hw;
    word_t count_hw;

    always_comb begin
        flags_hw = words[W_FLAGS] & ~STAT_MASK;
        flags_hw[op.ok ? F_TC : F_MERR] = 1'b1;
        count_hw = op.ok ? (words[W_COUNT] - op.len) : words[W_COUNT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else begin
            for (int w = 0; w < WORDS_PER_CH; w++) begin
                if (sw_we[w])
                    words[w] <= sw_data;
                else if (op.upd && w == W_FLAGS)
                    words[w] <= flags_hw;
                else if (op.upd && w == W_COUNT)
                    words[w] <= count_hw;
            end
        end
    end

    // R3
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (op.upd && !sw_we[W_FLAGS]) |=> ($onehot(words[W_FLAGS][F_MERR:F_TC]) && !words[W_FLAGS][F_AERR]));

    // R4
    fail_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op.upd && !op.ok && !sw_we[W_COUNT]) |=> $stable(words[W_COUNT]));

    // R5
    count_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_we[W_COUNT] |=> (words[W_COUNT] <= $past(words[W_COUNT])));

    // R9
    spare_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_we[W_SPARE] |=> $stable(words[W_SPARE]));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    input  logic [NUM_CH-1:0]        req_vld,
    input  logic [NUM_CH-1:0]        req_to_mem,
    input  logic [NUM_CH*WORD_W-1:0] req_len,
    output logic [NUM_CH-1:0]        req_ack,
    output logic                     rsp_vld,
    output logic [CH_W-1:0]          rsp_ch,
    output logic                     rsp_ok,
    output logic [WORD_W-1:0]        rsp_addr,
    output logic [WORD_W-1:0]        rsp_len
);
    dec_t dec;
    assign dec = decode(32'(reg_addr), NUM_CH);

    logic [WORDS_PER_CH-1:0][WORD_W-1:0] ch_words [NUM_CH];

    logic [NUM_CH-1:0] gnt;
    logic              gnt_any;
    logic [CH_W-1:0]   gnt_idx;

    dma_req_arb #(.NUM(NUM_CH), .IDX_W(CH_W)) u_arb (
        .req (req_vld),
        .gnt (gnt),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    assign req_ack = gnt;

    word_t sel_flags, sel_count, sel_addr, sel_want, glen;
    logic  legal;

    always_comb begin
        sel_flags = ch_words[gnt_idx][W_FLAGS];
        sel_count = ch_words[gnt_idx][W_COUNT];
        sel_addr  = ch_words[gnt_idx][W_ADDR];
        sel_want  = req_len[gnt_idx*WORD_W +: WORD_W];
        legal     = req_legal(sel_flags, req_to_mem[gnt_idx]);
        glen      = clamp_len(sel_want, sel_count);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORDS_PER_CH-1:0] sw_we;
        hw_op_t                  op;

        always_comb begin
            for (int w = 0; w < WORDS_PER_CH; w++)
                sw_we[w] = reg_we && dec.hit_ch && (dec.ch == 8'(c)) && (dec.idx == 2'(w));
            op.upd = gnt[c];
            op.ok  = legal;
            op.len = glen;
        end

        dma_chan_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .sw_we   (sw_we),
            .sw_data (reg_wdata),
            .op      (op),
            .words   (ch_words[c])
        );
    end

    logic [NUM_CH-1:0] err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q    <= '0;
            rsp_vld  <= 1'b0;
            rsp_ch   <= '0;
            rsp_ok   <= 1'b0;
            rsp_addr <= '0;
            rsp_len  <= '0;
        end else begin
            rsp_vld  <= gnt_any;
            rsp_ch   <= gnt_any ? gnt_idx : '0;
            rsp_ok   <= gnt_any && legal;
            rsp_addr <= (gnt_any && legal) ? sel_addr : '0;
            rsp_len  <= (gnt_any && legal) ? glen : '0;
            if (gnt_any && !legal)
                err_q[gnt_idx] <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (dec.hit_ch)
            reg_rdata = ch_words[dec.ch[CH_W-1:0]][dec.idx];
        else if (dec.hit_err)
            reg_rdata = WORD_W'(err_q);
    end

    // R6
    gnt_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_any |-> (((gnt & ~req_vld) == '0) && ((req_vld & (gnt - 1'b1)) == '0)));

    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ack));

    // R4
    fail_marks_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp_ok) |-> err_q[rsp_ch]);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;
    localparam int NCH = 8;
    localparam int AW  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0]     reg_addr  = '0;
    logic              reg_we    = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    req_vld    = '0;
    logic [NCH-1:0]    req_to_mem = '0;
    logic [NCH*32-1:0] req_len    = '0;
    logic [NCH-1:0]    req_ack;
    logic              rsp_vld;
    logic [2:0]        rsp_ch;
    logic              rsp_ok;
    logic [31:0]       rsp_addr, rsp_len;

    dma_chan_ctl #(.NUM_CH(NCH), .ADDR_W(AW)) i_dma_chan_ctl (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_vld(req_vld), .req_to_mem(req_to_mem), .req_len(req_len), .req_ack(req_ack),
        .rsp_vld(rsp_vld), .rsp_ch(rsp_ch), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr), .rsp_len(rsp_len)
    );

    int    total = 0;
    int    bad   = 0;
    string cur_tag = "R1";
    bit    finished = 0;

    // Behavioural reference model
    logic [31:0] m_w  [NCH][4];
    logic [31:0] nw   [NCH][4];
    logic [31:0] m_err;
    logic        e_vld, e_ok;
    int          e_ch;
    logic [31:0] e_addr, e_len;

    always @(posedge clk) begin
        int          pick;
        int          a;
        logic [31:0] fl, cnt, want, got;
        if (rst) begin
            for (int c = 0; c < NCH; c++)
                for (int w = 0; w < 4; w++) m_w[c][w] = 0;
            m_err = 0; e_vld = 0; e_ok = 0; e_ch = 0; e_addr = 0; e_len = 0;
        end else begin
            nw   = m_w;
            pick = -1;
            for (int c = NCH - 1; c >= 0; c--) if (req_vld[c]) pick = c;
            e_vld = (pick >= 0); e_ok = 0; e_ch = 0; e_addr = 0; e_len = 0;
            if (pick >= 0) begin
                e_ch = pick;
                fl   = m_w[pick][1];
                fl[10:8] = 3'b000;
                cnt  = m_w[pick][2];
                want = req_len[pick*32 +: 32];
                got  = (want < cnt) ? want : cnt;
                if (fl[0] && (req_to_mem[pick] != fl[1])) begin
                    fl[8] = 1'b1;
                    nw[pick][2] = cnt - got;
                    e_ok = 1; e_addr = m_w[pick][3]; e_len = got;
                end else begin
                    fl[9] = 1'b1;
                    m_err[pick] = 1'b1;
                end
                nw[pick][1] = fl;
            end
            if (reg_we) begin
                a = int'(reg_addr) & ~3;
                if (a >= 256 && a < 256 + 32 * NCH && (a % 8) == 0)
                    nw[(a - 256) / 32][(a / 8) % 4] = reg_wdata;
            end
            m_w = nw;
        end
    end

    function automatic logic [31:0] m_read(input logic [AW-1:0] ad);
        int a;
        a = int'(ad) & ~3;
        if (a >= 256 && a < 256 + 32 * NCH && (a % 8) == 0) return m_w[(a - 256) / 32][(a / 8) % 4];
        if (a == 512) return m_err;
        return 32'h0;
    endfunction

    function automatic logic [NCH-1:0] low_bit(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return NCH'(1) << i;
        return '0;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check("req_ack", 32'(req_ack), 32'(low_bit(req_vld)));
        check("rsp_vld", 32'(rsp_vld), 32'(e_vld));
        if (e_vld) begin
            check("rsp_ch",   32'(rsp_ch), e_ch);
            check("rsp_ok",   32'(rsp_ok), 32'(e_ok));
            check("rsp_addr", rsp_addr, e_addr);
            check("rsp_len",  rsp_len, e_len);
        end
        check("reg_rdata", reg_rdata, m_read(reg_addr));
        req_vld = req_vld & ~req_ack;
    endtask

    task automatic rd(input int a);
        reg_addr = AW'(a);
        cyc();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = AW'(a); reg_we = 1'b1; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
        cyc();
    endtask

    task automatic req(input int c, input logic tm, input logic [31:0] len);
        req_vld[c] = 1'b1;
        req_to_mem[c] = tm;
        req_len[c*32 +: 32] = len;
    endtask

    task automatic drain();
        while (req_vld != '0) cyc();
        cyc();
    endtask

    function automatic int ofs(input int c, input int w);
        return 256 + 32 * c + 8 * w;
    endfunction

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) cyc();
        rst = 1'b0;
        rd(ofs(0, 1)); rd(ofs(7, 3)); rd(512);

        // R2 / R9: full map write and read-back with low address bits set
        cur_tag = "R2";
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 4; w++)
                wr(ofs(c, w) | (c % 4), 32'hA500_0000 | (c << 8) | w);
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 4; w++) rd(ofs(c, w) | 3);
        wr(256 + 4, 32'hDEAD_BEEF); rd(256 + 4); rd(256);
        wr(32'h3F0, 32'h1234); rd(32'h3F0);
        cur_tag = "R9";
        wr(ofs(5, 0), 32'h5A5A_0001); rd(ofs(5, 0));

        // R5: channel setup and passing requests
        cur_tag = "R5";
        wr(ofs(0, 1), 32'h1);   wr(ofs(0, 2), 100); wr(ofs(0, 3), 32'h1000);
        wr(ofs(1, 1), 32'h3);   wr(ofs(1, 2), 50);  wr(ofs(1, 3), 32'h2000);
        wr(ofs(2, 1), 32'h0);   wr(ofs(2, 2), 10);
        wr(ofs(3, 1), 32'h701); wr(ofs(3, 2), 8);   wr(ofs(3, 3), 32'h3000);
        req(0, 1, 40); drain(); rd(ofs(0, 2));
        req(0, 1, 80); drain(); rd(ofs(0, 2));
        req(0, 1, 5);  drain(); rd(ofs(0, 1));
        req(1, 0, 20); drain(); rd(ofs(1, 2));

        // R4: direction mismatch and disabled channel
        cur_tag = "R4";
        req(1, 1, 20); drain(); rd(ofs(1, 1)); rd(ofs(1, 2));
        req(2, 1, 4);  drain(); rd(512);

        // R3: stale status bits cleared
        cur_tag = "R3";
        req(3, 1, 3); drain(); rd(ofs(3, 1));
        req(1, 0, 1); drain(); rd(ofs(1, 1));

        // R6: simultaneous requests served in ascending order
        cur_tag = "R6";
        wr(ofs(5, 1), 32'h1); wr(ofs(5, 2), 64); wr(ofs(7, 1), 32'h3); wr(ofs(7, 2), 9);
        req(7, 0, 2); req(5, 1, 16); req(3, 1, 1); req(1, 0, 2); req(2, 0, 1);
        drain(); rd(ofs(5, 2));

        // R7: software write collides with request update
        cur_tag = "R7";
        wr(ofs(0, 1), 32'h1); wr(ofs(0, 2), 100);
        req(0, 1, 10);
        reg_addr = AW'(ofs(0, 2)); reg_we = 1'b1; reg_wdata = 32'd500;
        cyc(); reg_we = 1'b0; drain(); rd(ofs(0, 2));
        req(0, 1, 10);
        reg_addr = AW'(ofs(0, 1)); reg_we = 1'b1; reg_wdata = 32'h3;
        cyc(); reg_we = 1'b0; drain(); rd(ofs(0, 1)); rd(ofs(0, 2));

        // R8: error-source register ignores writes
        cur_tag = "R8";
        wr(512, 32'h0); rd(512);
        wr(512 | 2, 32'hFFFF_FFFF); rd(512);

        // R6 (random): mixed requests and colliding writes
        cur_tag = "R6";
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                int c;
                c = $urandom_range(0, NCH - 1);
                req(c, 1'($urandom_range(0, 1)), 32'($urandom_range(0, 40)));
            end
            if ($urandom_range(0, 3) == 0) begin
                int c, w;
                c = $urandom_range(0, NCH - 1);
                w = $urandom_range(0, 3);
                reg_we = 1'b1;
                reg_addr = AW'(ofs(c, w) | $urandom_range(0, 3));
                reg_wdata = (w == 1) ? 32'($urandom_range(0, 3)) : 32'($urandom_range(0, 200));
            end else begin
                reg_we = 1'b0;
                reg_addr = AW'($urandom_range(0, 1023));
            end
            cyc();
        end
        reg_we = 1'b0;
        drain();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule